// File: doc/BRIEF.md
# Event-Number Hit Distribution Switch

This block sits behind the receivers of one detector layer. Several input links each deliver a stream of words into a private input FIFO. A word is either a hit (a position plus the event number, or time stamp, it belongs to) or an end-of-event marker carrying an event number. The switch takes at most one word per clock from the input FIFOs, chosen by a rotating arbiter. It steers each hit to one of several output lanes, picked by the event number. Each lane feeds one pattern matcher, so consecutive events are matched in parallel rather than one after another.

Each lane owns an output FIFO and hands its matcher at most one word per clock under a valid/ready handshake. A full lane only holds back the input whose next hit is bound for that lane. The other inputs keep moving, which absorbs swings in the number of hits per event. Once an input has handed over its end-of-event marker, it is held until every input has done the same. A single marker for that event is then written into the event's lane, behind all of the event's hits.

Top module: `evsw_top`

## Requirements
- R1: While reset is held and in the first cycle after it, every `out_valid` bit is low and every `in_ready` bit is high.
- R2: A hit with event number E is delivered only on lane E mod N_LANE (8 by default), with `out_eoe`=0 and its event number and position unchanged.
- R3: Hits from one input that go to the same lane leave that lane in the order they were accepted.
- R4: Each lane presents at most one word per clock. While `out_valid` is high and `out_ready` is low, the lane keeps `out_valid` high and its word unchanged.
- R5: Inputs that all hold eligible hits are served one word per clock in rotating order (input k, then k+1 mod N_IN, and so on).
- R6: A full lane stalls only the input whose head hit targets it. Hits for other lanes from other inputs keep flowing, and no stalled hit is lost or reordered once the lane drains.
- R7: An input's `in_ready` goes low once its FIFO holds IN_DEPTH words. `in_valid` is only honoured while `in_ready` is high.
- R8: A word with `out_eoe`=1 and event number E appears on lane E mod N_LANE exactly once, only after every input has delivered its marker for E. It comes after all hits of E from all inputs, and its position field is 0.
- R9: After an input's marker has been taken, none of that input's later words are forwarded until the combined marker has been written.
- R10: Lanes run independently. Lanes holding words all deliver in the same clock when their `out_ready` rises together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | N_IN | Word present on each input link |
| in_ready | output | N_IN | Input FIFO can accept a word |
| in_eoe | input | N_IN | Word is an end-of-event marker |
| in_evt | input | N_IN*EVT_W | Event number per input, input i at bits i*EVT_W |
| in_pos | input | N_IN*POS_W | Hit position per input, input i at bits i*POS_W |
| out_valid | output | N_LANE | Lane holds a word for its matcher |
| out_ready | input | N_LANE | Matcher takes the lane's word this clock |
| out_eoe | output | N_LANE | Lane word is an end-of-event marker |
| out_evt | output | N_LANE*EVT_W | Event number per lane |
| out_pos | output | N_LANE*POS_W | Hit position per lane |

## Verification
A wrong lane index shows up as a hit on the wrong lane two clocks after it is written. A stale done flag shows up in one of two ways: an input whose next-event hits never leave, or a marker that appears before the last input's marker. The bench catches both within about twenty cycles. A broken arbiter pointer breaks the rotation of same-cycle hits on a shared lane. Lost or duplicated lane FIFO entries show as missing or repeated positions once the backed-up lane drains.

// File: rtl/evsw_pkg.sv
package evsw_pkg;

  // Lane chosen for an event number: plain modulo of the lane count.
  function automatic int unsigned lane_of(input logic [31:0] evt, input int unsigned lanes);
    return evt % lanes;
  endfunction

  // Next index of a rotating pointer over n slots.
  function automatic int unsigned rot_next(input int unsigned idx, input int unsigned n);
    return (idx + 1) % n;
  endfunction

endpackage

// File: rtl/evsw_fifo.sv
module evsw_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          do_push, do_pop;

  assign empty   = (cnt == '0);
  assign full    = (cnt == (AW+1)'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
      cnt <= cnt + (AW+1)'(do_push) - (AW+1)'(do_pop);
    end
  end
endmodule

// File: rtl/evsw_rr_arb.sv
module evsw_rr_arb import evsw_pkg::*; #(
  parameter int N = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         req,
  output logic [N-1:0]         grant,
  output logic [$clog2(N)-1:0] grant_idx,
  output logic                 any
);
  localparam int IW = $clog2(N);

  logic [IW-1:0] ptr;
  logic          found;

  always_comb begin
    grant     = '0;
    grant_idx = '0;
    found     = 1'b0;
    for (int k = 0; k < N; k++) begin
      if (!found && req[(int'(ptr) + k) % N]) begin
        found                     = 1'b1;
        grant[(int'(ptr) + k) % N] = 1'b1;
        grant_idx                 = IW'((int'(ptr) + k) % N);
      end
    end
  end

  assign any = found;

  always_ff @(posedge clk) begin
    if (!rst_n)   ptr <= '0;
    else if (any) ptr <= IW'(rot_next(int'(grant_idx), N));
  end
endmodule

// File: rtl/evsw_top.sv
module evsw_top import evsw_pkg::*; #(
  parameter int N_IN      = 4,
  parameter int N_LANE    = 8,
  parameter int EVT_W     = 8,
  parameter int POS_W     = 12,
  parameter int IN_DEPTH  = 4,
  parameter int OUT_DEPTH = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_IN-1:0]         in_valid,
  output logic [N_IN-1:0]         in_ready,
  input  logic [N_IN-1:0]         in_eoe,
  input  logic [N_IN*EVT_W-1:0]   in_evt,
  input  logic [N_IN*POS_W-1:0]   in_pos,
  output logic [N_LANE-1:0]       out_valid,
  input  logic [N_LANE-1:0]       out_ready,
  output logic [N_LANE-1:0]       out_eoe,
  output logic [N_LANE*EVT_W-1:0] out_evt,
  output logic [N_LANE*POS_W-1:0] out_pos
);
  localparam int WORD_W = 1 + EVT_W + POS_W;
  localparam int LW     = $clog2(N_LANE);
  localparam int IW     = $clog2(N_IN);
  localparam int EOE_B  = WORD_W - 1;
  localparam int EVT_HI = WORD_W - 2;

  // Input side
  logic [WORD_W-1:0] head      [N_IN];
  logic [LW-1:0]     head_lane [N_IN];
  logic [N_IN-1:0]   in_empty, in_full, eligible, grant_vec, done_vec;

  // Arbiter result
  logic              any_grant;
  logic [IW-1:0]     gidx;
  logic [WORD_W-1:0] sel_word;
  logic [LW-1:0]     sel_lane;

  // Named internal events, used by the checker
  logic              hit_push, eoe_take, marker_push, all_done;
  logic [EVT_W-1:0]  mark_evt;
  logic [LW-1:0]     mark_lane;

  // Lane side
  logic [N_LANE-1:0]        lane_full, lane_empty, lane_push;
  logic [WORD_W-1:0]        lane_din  [N_LANE];
  logic [WORD_W-1:0]        lane_dout [N_LANE];
  logic [N_LANE*WORD_W-1:0] lane_dout_flat;

  for (genvar i = 0; i < N_IN; i++) begin : g_in
    evsw_fifo #(.W(WORD_W), .DEPTH(IN_DEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (in_valid[i]),
      .din   ({in_eoe[i], in_evt[i*EVT_W +: EVT_W], in_pos[i*POS_W +: POS_W]}),
      .pop   (grant_vec[i]),
      .dout  (head[i]),
      .empty (in_empty[i]),
      .full  (in_full[i])
    );
    assign in_ready[i]  = !in_full[i];
    assign head_lane[i] = LW'(lane_of(32'(head[i][EVT_HI -: EVT_W]), N_LANE));
    // A marker never needs lane space; a hit needs room in its lane.
    assign eligible[i]  = !in_empty[i] && !done_vec[i] &&
                          (head[i][EOE_B] || !lane_full[head_lane[i]]);
  end

  evsw_rr_arb #(.N(N_IN)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (eligible),
    .grant     (grant_vec),
    .grant_idx (gidx),
    .any       (any_grant)
  );

  assign sel_word  = head[gidx];
  assign sel_lane  = head_lane[gidx];
  assign hit_push  = any_grant && !sel_word[EOE_B];
  assign eoe_take  = any_grant &&  sel_word[EOE_B];
  assign all_done  = &done_vec;
  assign mark_lane = LW'(lane_of(32'(mark_evt), N_LANE));
  assign marker_push = all_done && !lane_full[mark_lane];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_vec <= '0;
      mark_evt <= '0;
    end else if (marker_push) begin
      done_vec <= '0;
    end else if (eoe_take) begin
      done_vec <= done_vec | grant_vec;
      mark_evt <= sel_word[EVT_HI -: EVT_W];
    end
  end

  for (genvar l = 0; l < N_LANE; l++) begin : g_lane
    assign lane_push[l] = (hit_push    && (sel_lane  == LW'(l))) ||
                          (marker_push && (mark_lane == LW'(l)));
    assign lane_din[l]  = marker_push ? {1'b1, mark_evt, {POS_W{1'b0}}} : sel_word;

    evsw_fifo #(.W(WORD_W), .DEPTH(OUT_DEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (lane_push[l]),
      .din   (lane_din[l]),
      .pop   (out_ready[l]),
      .dout  (lane_dout[l]),
      .empty (lane_empty[l]),
      .full  (lane_full[l])
    );

    assign out_valid[l]                 = !lane_empty[l];
    assign out_eoe[l]                   = lane_dout[l][EOE_B];
    assign out_evt[l*EVT_W +: EVT_W]    = lane_dout[l][EVT_HI -: EVT_W];
    assign out_pos[l*POS_W +: POS_W]    = lane_dout[l][POS_W-1:0];
    assign lane_dout_flat[l*WORD_W +: WORD_W] = lane_dout[l];
  end
endmodule

// File: rtl/evsw_check.sv
module evsw_check #(
  parameter int N_IN   = 4,
  parameter int N_LANE = 8,
  parameter int WORD_W = 21
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [N_IN-1:0]          grant_vec,
  input logic [N_IN-1:0]          done_vec,
  input logic                     hit_push,
  input logic                     marker_push,
  input logic [N_LANE-1:0]        lane_push,
  input logic [N_LANE-1:0]        lane_full,
  input logic [N_LANE-1:0]        out_valid,
  input logic [N_LANE-1:0]        out_ready,
  input logic [N_LANE*WORD_W-1:0] out_word
);
  assert_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (out_valid == '0));

  assert_one_lane_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hit_push |-> ($countones(lane_push) == 1));

  assert_grant_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_vec));

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((lane_push & lane_full) == '0));

  assert_marker_after_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
    marker_push |-> (&done_vec));

  assert_done_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant_vec & done_vec) == '0));

  for (genvar l = 0; l < N_LANE; l++) begin : g_hold
    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid[l] && !out_ready[l]) |=>
        (out_valid[l] && $stable(out_word[l*WORD_W +: WORD_W])));
  end
endmodule

bind evsw_top evsw_check #(.N_IN(N_IN), .N_LANE(N_LANE), .WORD_W(WORD_W)) u_check (
  .clk         (clk),
  .rst_n       (rst_n),
  .grant_vec   (grant_vec),
  .done_vec    (done_vec),
  .hit_push    (hit_push),
  .marker_push (marker_push),
  .lane_push   (lane_push),
  .lane_full   (lane_full),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_word    (lane_dout_flat)
);

// File: tb/evsw_top_test.sv
module evsw_top_test;
  localparam int N_IN = 4, N_LANE = 8, EVT_W = 8, POS_W = 12, IN_DEPTH = 4, OUT_DEPTH = 4;
  localparam int WORD_W = 1 + EVT_W + POS_W;

  logic clk = 0, rst_n = 0;
  logic [N_IN-1:0] in_valid = '0, in_eoe = '0, in_ready;
  logic [N_IN*EVT_W-1:0] in_evt = '0;
  logic [N_IN*POS_W-1:0] in_pos = '0;
  logic [N_LANE-1:0] out_valid, out_eoe;
  logic [N_LANE-1:0] out_ready = '1;
  logic [N_LANE*EVT_W-1:0] out_evt;
  logic [N_LANE*POS_W-1:0] out_pos;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit finished = 0;

  logic [WORD_W-1:0] lg_w [256];
  int lg_l [256];
  int lg_c [256];
  int n_log = 0;

  evsw_top #(.N_IN(N_IN), .N_LANE(N_LANE), .EVT_W(EVT_W), .POS_W(POS_W),
             .IN_DEPTH(IN_DEPTH), .OUT_DEPTH(OUT_DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_eoe(in_eoe), .in_evt(in_evt), .in_pos(in_pos),
    .out_valid(out_valid), .out_ready(out_ready), .out_eoe(out_eoe),
    .out_evt(out_evt), .out_pos(out_pos));

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Handshake monitor: inputs change 2 ns after a rising edge, so the
  // falling edge sees the values the next rising edge will act on.
  always @(negedge clk) begin
    if (rst_n) begin
      for (int l = 0; l < N_LANE; l++) begin
        if (out_valid[l] && out_ready[l] && n_log < 256) begin
          lg_w[n_log] = {out_eoe[l], out_evt[l*EVT_W +: EVT_W], out_pos[l*POS_W +: POS_W]};
          lg_l[n_log] = l;
          lg_c[n_log] = cyc;
          n_log++;
        end
      end
    end
  end

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic wait_n(input int n);
    for (int k = 0; k < n; k++) tick();
  endtask

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic set_in(input int i, input bit e, input int ev, input int p);
    in_valid[i] = 1'b1;
    in_eoe[i]   = e;
    in_evt[i*EVT_W +: EVT_W] = EVT_W'(ev);
    in_pos[i*POS_W +: POS_W] = POS_W'(p);
  endtask

  task automatic send(input int i, input bit e, input int ev, input int p);
    while (!in_ready[i]) tick();
    set_in(i, e, ev, p);
    tick();
    in_valid[i] = 1'b0;
  endtask

  function automatic int w_eoe(input int idx); return int'(lg_w[idx][WORD_W-1]); endfunction
  function automatic int w_evt(input int idx); return int'(lg_w[idx][WORD_W-2 -: EVT_W]); endfunction
  function automatic int w_pos(input int idx); return int'(lg_w[idx][POS_W-1:0]); endfunction

  // Entries on a lane since base; sel: 0 hits, 1 markers, 2 any
  function automatic int cnt_lane(input int lane, input int base, input int sel);
    int c = 0;
    for (int k = base; k < n_log; k++)
      if (lg_l[k] == lane && (sel == 2 || w_eoe(k) == sel)) c++;
    return c;
  endfunction

  function automatic int nth(input int lane, input int base, input int n);
    int c = 0;
    for (int k = base; k < n_log; k++)
      if (lg_l[k] == lane) begin
        if (c == n) return k;
        c++;
      end
    return -1;
  endfunction

  task automatic t_reset();
    chk(out_valid == '0, "R1", "out_valid after reset", int'(out_valid), 0);
    chk(in_ready == '1, "R1", "in_ready after reset", int'(in_ready), 15);
  endtask

  task automatic t_route();
    int base = n_log;
    int evs[3] = '{3, 12, 7};
    for (int k = 0; k < 3; k++) send(1, 0, evs[k], 40 + k);
    wait_n(8);
    for (int k = 0; k < 3; k++) begin
      int idx = nth(evs[k] % N_LANE, base, 0);
      chk(idx >= 0, "R2", "hit on lane evt mod 8", idx, 0);
      if (idx >= 0) begin
        chk(w_pos(idx) == 40 + k, "R2", "position", w_pos(idx), 40 + k);
        chk(w_evt(idx) == evs[k] && w_eoe(idx) == 0, "R2", "event", w_evt(idx), evs[k]);
      end
    end
    chk(n_log - base == 3, "R2", "total words", n_log - base, 3);
  endtask

  task automatic t_order();
    int base = n_log;
    for (int k = 0; k < 5; k++) send(2, 0, 9, 100 + k);
    wait_n(8);
    for (int k = 0; k < 5; k++) begin
      int idx = nth(1, base, k);
      chk(idx >= 0 && w_pos(idx) == 100 + k, "R3", "lane1 order",
          (idx >= 0) ? w_pos(idx) : -1, 100 + k);
    end
  endtask

  task automatic t_rr();
    int base = n_log;
    for (int i = 0; i < N_IN; i++) set_in(i, 0, 20, 200 + i);
    tick();
    in_valid = '0;
    wait_n(10);
    chk(cnt_lane(4, base, 0) == 4, "R5", "lane4 count", cnt_lane(4, base, 0), 4);
    for (int k = 0; k < 3; k++) begin
      int a = nth(4, base, k), b = nth(4, base, k + 1);
      if (a >= 0 && b >= 0)
        chk((w_pos(b) - 200) == (w_pos(a) - 200 + 1) % 4, "R5", "rotation",
            w_pos(b) - 200, (w_pos(a) - 200 + 1) % 4);
    end
  endtask

  task automatic t_backpressure();
    int base = n_log;
    logic [POS_W-1:0] held;
    out_ready[0] = 1'b0;
    for (int k = 0; k < 8; k++) send(0, 0, 0, 500 + k);
    for (int k = 0; k < 3; k++) send(1, 0, 1, 600 + k);
    wait_n(10);
    chk(in_ready[0] == 1'b0, "R7", "in_ready with full input FIFO", int'(in_ready[0]), 0);
    chk(cnt_lane(1, base, 2) == 3, "R6", "other lane flows", cnt_lane(1, base, 2), 3);
    chk(cnt_lane(0, base, 2) == 0, "R6", "blocked lane silent", cnt_lane(0, base, 2), 0);
    held = out_pos[POS_W-1:0];
    wait_n(3);
    chk(out_valid[0] && out_pos[POS_W-1:0] == held, "R4", "lane0 held word",
        int'(out_pos[POS_W-1:0]), int'(held));
    out_ready[0] = 1'b1;
    wait_n(15);
    chk(cnt_lane(0, base, 2) == 8, "R6", "lane0 drained", cnt_lane(0, base, 2), 8);
    for (int k = 0; k < 8; k++) begin
      int idx = nth(0, base, k);
      chk(idx >= 0 && w_pos(idx) == 500 + k, "R6", "lane0 order",
          (idx >= 0) ? w_pos(idx) : -1, 500 + k);
    end
    chk(in_ready[0] == 1'b1, "R7", "in_ready after drain", int'(in_ready[0]), 1);
  endtask

  task automatic t_eoe();
    int base = n_log, last;
    for (int i = 0; i < 3; i++) begin
      send(i, 0, 30, 300 + i);
      send(i, 1, 30, 0);
    end
    send(0, 0, 31, 310);
    wait_n(20);
    chk(cnt_lane(6, base, 0) == 3, "R8", "lane6 hits before last marker", cnt_lane(6, base, 0), 3);
    chk(cnt_lane(6, base, 1) == 0, "R8", "no early marker", cnt_lane(6, base, 1), 0);
    chk(cnt_lane(7, base, 2) == 0, "R9", "next event held", cnt_lane(7, base, 2), 0);
    send(3, 0, 30, 303);
    send(3, 1, 30, 0);
    wait_n(20);
    chk(cnt_lane(6, base, 0) == 4, "R8", "lane6 hits", cnt_lane(6, base, 0), 4);
    chk(cnt_lane(6, base, 1) == 1, "R8", "one marker", cnt_lane(6, base, 1), 1);
    last = nth(6, base, 4);
    chk(last >= 0 && w_eoe(last) == 1 && w_evt(last) == 30 && w_pos(last) == 0,
        "R8", "marker last with evt 30", (last >= 0) ? w_evt(last) : -1, 30);
    chk(cnt_lane(7, base, 0) == 1, "R9", "next event released", cnt_lane(7, base, 0), 1);
  endtask

  task automatic t_parallel();
    int base = n_log, a, b;
    out_ready = '0;
    set_in(0, 0, 2, 700);
    set_in(1, 0, 3, 701);
    tick();
    in_valid = '0;
    wait_n(6);
    out_ready = '1;
    wait_n(4);
    a = nth(2, base, 0);
    b = nth(3, base, 0);
    chk(a >= 0 && b >= 0 && lg_c[a] == lg_c[b], "R10", "same-cycle delivery",
        (a >= 0) ? lg_c[a] : -1, (b >= 0) ? lg_c[b] : -1);
  endtask

  initial begin
    wait_n(3);
    #1;
    chk(out_valid == '0 && in_ready == '1, "R1", "during reset", int'(out_valid), 0);
    rst_n = 1'b1;
    tick();
    t_reset();
    t_route();
    t_order();
    t_rr();
    t_backpressure();
    t_eoe();
    t_parallel();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule